// File: doc/BRIEF.md
# Double-Buffered Dual DAC Write Port

This block is the host-side register port for a pair of 12-bit digital-to-analog channels. The host writes one byte per bus cycle into a small I/O window. Each channel has a low-byte location and a high-byte location. A low-byte write only parks its byte in a per-channel staging register. The matching high-byte write then moves the staged byte and the new upper bits into the channel's converter code in a single clock edge. The analog side therefore never sees a code whose low and high parts come from different updates.

The window shares its offsets with read-only input registers that sit elsewhere. Only the write strobe selects this block, so read traffic at the same offsets leaves every register here as it is. Each channel drives a parallel code and a one-clock update pulse. Downstream logic can use that pulse to latch or settle the converter.

Top module: `dac_pair_wport`

## Requirements
- R1: Channel n has its low-byte location at offset BASE_OFS+2n and its high-byte location at BASE_OFS+2n+1. With the defaults, channel 0 uses offsets 4 and 5 and channel 1 uses offsets 6 and 7. Code n appears on `dac_code[12n+11:12n]`.
- R2: The low byte supplies code bits 7..0. Bits 3..0 of a high-byte write supply code bits 11..8, and bits 7..4 of that write have no effect.
- R3: A low-byte write loads only that channel's staging register. Neither channel's code changes and no update pulse is raised.
- R4: A high-byte write replaces the channel's whole code with {new high bits, staged low byte} in one step. The new code is visible in the cycle after the write. The other channel's code stays the same.
- R5: A bus cycle with `bus_wr` low, at any offset, changes no code and raises no pulse. The same holds for a write to an offset outside the window.
- R6: `dac_upd[n]` is high for exactly the one cycle after a high-byte write to channel n and is low otherwise. At most one pulse bit is high at any time.
- R7: Reset clears both codes, both staging registers and both pulses to zero.
- R8: A second high-byte write with no low-byte write in between reuses the low byte staged earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset within the host window |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| dac_code | output | 24 | Two 12-bit converter codes, channel 0 in the low half |
| dac_upd | output | 2 | Per-channel update pulse |

## Verification
Every result is due one clock edge after the bus cycle that causes it. A committed code and its update pulse appear together in the cycle after the high-byte write. A low-byte write shows no change in that same cycle. The pulse must be gone one cycle later.

The bench drives each bus cycle so that it spans exactly one rising edge. It samples two nanoseconds after that edge and then idles for one cycle to confirm the pulse has dropped. It sweeps every high-byte value on both channels with varied staged bytes, and repeats high-byte writes to check that the staged byte is reused. It then presents every offset as a read, and every offset outside the window as a write, and checks that nothing moves.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
   // Offset of a channel's low-byte location; the high byte follows at +1.
   function automatic int unsigned lo_offset(input int unsigned base, input int unsigned ch);
      return base + 2 * ch;
   endfunction
endpackage

// File: rtl/dacw_decode.sv
module dacw_decode #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BASE_OFS = 4,
   parameter int unsigned NUM_CH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   output logic [NUM_CH-1:0] lo_we,
   output logic [NUM_CH-1:0] hi_we
);
   localparam int unsigned SPAN = 2 * NUM_CH;

   initial begin
      if (BASE_OFS % 2 != 0) $error("BASE_OFS must be even");
      if (BASE_OFS + SPAN > (1 << ADDR_W)) $error("window does not fit in address space");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int unsigned LO = dacw_pkg::lo_offset(BASE_OFS, i);
      assign lo_we[i] = bus_wr && (bus_addr == ADDR_W'(LO));
      assign hi_we[i] = bus_wr && (bus_addr == ADDR_W'(LO + 1));
   end

   // R5: with no write strobe, nothing is selected
   assert_read_selects_nothing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |-> (lo_we == '0 && hi_we == '0));
   // R1: at most one location is selected per bus cycle
   assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_we, hi_we}));
endmodule

// File: rtl/dacw_channel.sv
module dacw_channel #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CODE_W-1:0] code,
   output logic              upd
);
   localparam int unsigned HI_W = CODE_W - BYTE_W;

   initial begin
      if (CODE_W <= BYTE_W) $error("CODE_W must exceed BYTE_W");
      if (HI_W > BYTE_W) $error("high part must fit in one byte");
   end

   logic [BYTE_W-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
         code  <= '0;
         upd   <= 1'b0;
      end else begin
         if (lo_we) stage <= wdata;
         if (hi_we) code <= {wdata[HI_W-1:0], stage};
         upd <= hi_we;
      end
   end

   // R3: low-byte write leaves the code alone
   assert_lo_holds_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !hi_we) |=> $stable(code));
   // R4: high-byte write commits staged byte plus new high bits together
   assert_hi_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |=> (code == {$past(wdata[HI_W-1:0]), $past(stage)}));
   // R6: the code moves only together with an update pulse
   assert_code_moves_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |-> $stable(code));
   // R6: a pulse always follows a high-byte write
   assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> $past(hi_we));
endmodule

// File: rtl/dac_pair_wport.sv
module dac_pair_wport #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BASE_OFS = 4,
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned BYTE_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [BYTE_W-1:0]        bus_wdata,
   input  logic                     bus_wr,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_upd
);
   initial begin
      if (NUM_CH < 1) $error("NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] lo_we, hi_we;

   dacw_decode #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS), .NUM_CH(NUM_CH)) u_decode (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .lo_we(lo_we), .hi_we(hi_we));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dacw_channel #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .lo_we(lo_we[i]), .hi_we(hi_we[i]),
         .wdata(bus_wdata), .code(dac_code[i*CODE_W +: CODE_W]), .upd(dac_upd[i]));
   end

   // R6: pulses never overlap across channels
   assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dac_upd));
   // R5: a cycle without a write strobe changes no code
   assert_read_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(dac_code) && dac_upd == '0));
endmodule

// File: tb/dac_pair_wport_bench.sv
`timescale 1ns/1ps
module dac_pair_wport_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [23:0] dac_code;
   logic [1:0]  dac_upd;

   int nchk = 0, nfail = 0;
   int exp_code [2];
   int exp_stage [2];
   bit done = 0;

   always #10 clk = ~clk;

   dac_pair_wport u_dac_pair_wport (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .dac_code(dac_code), .dac_upd(dac_upd));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int code_of(input int ch);
      return int'(dac_code[ch*12 +: 12]);
   endfunction

   task automatic check_codes(input string req);
      for (int c = 0; c < 2; c++) chk(code_of(c) == exp_code[c], req, code_of(c), exp_code[c]);
   endtask

   // one bus cycle spanning one rising edge, sampled 2 ns after it
   task automatic bus_cycle(input int a, input int d, input bit w);
      bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = w;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic idle_check(input string req);
      @(posedge clk); #2;
      chk(dac_upd == 2'b00, req, int'(dac_upd), 0);
   endtask

   task automatic write_hi(input int ch, input int hv, input string req);
      bus_cycle(4 + 2*ch + 1, hv, 1'b1);
      exp_code[ch] = ((hv & 15) << 8) | exp_stage[ch];
      check_codes(req);
      chk(dac_upd == 2'(1 << ch), req, int'(dac_upd), 1 << ch);
      idle_check("R6 pulse lasts one cycle");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 2; c++) begin exp_code[c] = 0; exp_stage[c] = 0; end
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      @(posedge clk); #2;
      check_codes("R7 reset codes");
      chk(dac_upd == 2'b00, "R7 reset pulses", int'(dac_upd), 0);

      // R7: staging registers are zero after reset; R2: upper nibble ignored
      write_hi(0, 8'hA5, "R7 R2 staged zero ch0");
      write_hi(1, 8'h3C, "R7 R2 staged zero ch1");

      // R1 R2 R3 R4 R6 R8: sweep every high byte on both channels
      for (int ch = 0; ch < 2; ch++) begin
         for (int hv = 0; hv < 256; hv++) begin
            int lo;
            lo = (hv * 37 + ch * 91 + 5) & 255;
            bus_cycle(4 + 2*ch, lo, 1'b1);
            exp_stage[ch] = lo;
            check_codes("R3 low write holds codes");
            chk(dac_upd == 2'b00, "R3 no pulse on low write", int'(dac_upd), 0);
            write_hi(ch, hv, "R4 R1 R2 commit");
            if (hv % 16 == 3) write_hi(ch, hv ^ 8'h5F, "R8 reuse staged byte");
         end
      end

      // R5: reads at every offset, and writes outside the window
      for (int a = 0; a < 16; a++) begin
         bus_cycle(a, (a * 17 + 1) & 255, 1'b0);
         check_codes("R5 read leaves codes");
         chk(dac_upd == 2'b00, "R5 read no pulse", int'(dac_upd), 0);
         if (a < 4 || a > 7) begin
            bus_cycle(a, 8'hFF, 1'b1);
            check_codes("R5 outside write leaves codes");
            chk(dac_upd == 2'b00, "R5 outside write no pulse", int'(dac_upd), 0);
         end
      end
      // R5: staging untouched by those cycles
      write_hi(0, 8'h07, "R5 staging kept ch0");
      write_hi(1, 8'h0E, "R5 staging kept ch1");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule